// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface and walks the device from the release of a synchronous reset to a ready state. It raises the clock enable and keeps it high. It holds the on-die termination control low. It waits out the reset-exit interval and then loads the four mode registers in the order the device demands. Next it starts a long ZQ calibration. Finally it waits for both DLL lock and ZQ initialization before it raises `init_done`. The four mode register values arrive on input ports. The sequencer forces the DLL-enable bit in the extended mode register and the DLL-reset bit in the main mode register. Every interval is a parameter counted in clock cycles.

The command is driven as the usual three active-low strobes packed into `cmd` as {row strobe, column strobe, write enable}. The encodings are: NOP = 3'b111, mode register set = 3'b000, ZQ calibration = 3'b110 with address bit 10 high for the long form.

The state machine has thirteen states:
- IDLE is the reset state. CKE is low and chip select is high.
- XPR is the reset-exit wait.
- LD_MR2, LD_MR3, LD_MR1 and LD_MR0 each issue one command.
- GAP2, GAP3 and GAP1 are the tMRD gaps.
- GAPM is the tMOD gap.
- ZQCL issues the calibration command.
- SETTLE is the combined DLL-lock and ZQ-init wait.
- DONE is the final state.

The transitions are:
- IDLE goes to XPR on the first clock with reset low.
- XPR, every gap state and SETTLE leave when the interval timer reports zero.
- XPR goes to LD_MR2.
- LD_MR2 goes to GAP2, then GAP2 to LD_MR3.
- LD_MR3 goes to GAP3, then GAP3 to LD_MR1.
- LD_MR1 goes to GAP1, then GAP1 to LD_MR0.
- LD_MR0 goes to GAPM, then GAPM to ZQCL.
- ZQCL goes to SETTLE, then SETTLE to DONE.
- Every command state lasts exactly one cycle.
- DONE holds until reset.
- Reset returns any state to IDLE.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `cke`=0, `cs_n`=1, `cmd`=3'b111 and `init_done`=0, including when reset arrives mid-sequence or after completion.
- R2: `cke` goes high in the first cycle after reset is released and stays high until the next reset.
- R3: `odt` is 0 in every cycle.
- R4: The first mode register set comes T_XPR cycles after the first cycle with `cke` high, where T_XPR is the larger of T_XS and 5.
- R5: The four mode register sets (`cmd`=3'b000, `cs_n`=0) appear in the order `ba`=3'b010, 3'b011, 3'b001, 3'b000. Each is issued T_MRD cycles after the previous one.
- R6: The set with `ba`=3'b001 drives `addr` equal to `mr1_val` with bit 0 forced to 0 (DLL enabled).
- R7: The set with `ba`=3'b000 drives `addr` equal to `mr0_val` with bit 8 forced to 1 (DLL reset). The sets with `ba`=3'b010 and 3'b011 carry `mr2_val` and `mr3_val` unchanged.
- R8: A long ZQ calibration (`cmd`=3'b110, `ba`=0, `addr` with only bit 10 set) is issued T_MOD cycles after the last mode register set.
- R9: `init_done` rises exactly max(T_DLLK, T_ZQINIT) cycles after the ZQ calibration command and stays high until reset.
- R10: Every cycle after reset release that carries none of the five commands is a NOP (`cmd`=3'b111) with `cs_n`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mr0_val | input | ADDR_W | Main mode register contents |
| mr1_val | input | ADDR_W | Extended mode register 1 contents |
| mr2_val | input | ADDR_W | Extended mode register 2 contents |
| mr3_val | input | ADDR_W | Extended mode register 3 contents |
| cke | output | 1 | Clock enable to the device |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| cmd | output | 3 | {row strobe, column strobe, write enable}, active low |
| ba | output | 3 | Bank address |
| addr | output | ADDR_W | Address bus / op-code |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The assertions assume that the mode register inputs stay stable while the sequence runs. They also assume the interval parameters are at least 2 and that ADDR_W is at least 11, so that bits 8 and 10 exist. The stimulus changes the mode register values only while reset is held. It uses the default intervals and a 16-bit address. It runs the sequence with two sets of register values: one with the DLL bits already correct and one with them set against the requirement. It also applies a reset in the middle of the tMOD gap and another reset after completion.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_XPR,
        S_LD_MR2,
        S_GAP2,
        S_LD_MR3,
        S_GAP3,
        S_LD_MR1,
        S_GAP1,
        S_LD_MR0,
        S_GAPM,
        S_ZQCL,
        S_SETTLE,
        S_DONE
    } seq_state_t;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] CMD_NOP = 3'b111;
    localparam logic [2:0] CMD_MRS = 3'b000;
    localparam logic [2:0] CMD_ZQC = 3'b110;

    localparam logic [2:0] BA_MR0 = 3'b000;
    localparam logic [2:0] BA_MR1 = 3'b001;
    localparam logic [2:0] BA_MR2 = 3'b010;
    localparam logic [2:0] BA_MR3 = 3'b011;

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst && !load) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ddr3_init_cmd_enc.sv
module ddr3_init_cmd_enc
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] mr0_val,
    input  logic [ADDR_W-1:0] mr1_val,
    input  logic [ADDR_W-1:0] mr2_val,
    input  logic [ADDR_W-1:0] mr3_val,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic [2:0]        cmd,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam logic [ADDR_W-1:0] DLL_EN_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] DLL_RST_BIT = ADDR_W'(1) << 8;
    localparam logic [ADDR_W-1:0] ZQ_LONG_BIT = ADDR_W'(1) << 10;

    always_comb begin
        cke       = 1'b1;
        odt       = 1'b0;
        cs_n      = 1'b0;
        cmd       = CMD_NOP;
        ba        = '0;
        addr      = '0;
        init_done = 1'b0;
        unique case (state)
            S_IDLE: begin
                cke  = 1'b0;
                cs_n = 1'b1;
            end
            S_LD_MR2: begin
                cmd  = CMD_MRS;
                ba   = BA_MR2;
                addr = mr2_val;
            end
            S_LD_MR3: begin
                cmd  = CMD_MRS;
                ba   = BA_MR3;
                addr = mr3_val;
            end
            S_LD_MR1: begin
                cmd  = CMD_MRS;
                ba   = BA_MR1;
                addr = mr1_val & ~DLL_EN_MASK;
            end
            S_LD_MR0: begin
                cmd  = CMD_MRS;
                ba   = BA_MR0;
                addr = mr0_val | DLL_RST_BIT;
            end
            S_ZQCL: begin
                cmd  = CMD_ZQC;
                addr = ZQ_LONG_BIT;
            end
            S_DONE: begin
                init_done = 1'b1;
            end
            S_XPR, S_GAP2, S_GAP3, S_GAP1, S_GAPM, S_SETTLE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int T_XS     = 8,
    parameter int T_MRD    = 4,
    parameter int T_MOD    = 12,
    parameter int T_DLLK   = 512,
    parameter int T_ZQINIT = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mr0_val,
    input  logic [ADDR_W-1:0] mr1_val,
    input  logic [ADDR_W-1:0] mr2_val,
    input  logic [ADDR_W-1:0] mr3_val,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic [2:0]        cmd,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int T_XPR   = (T_XS > 5) ? T_XS : 5;
    localparam int T_FINAL = (T_DLLK > T_ZQINIT) ? T_DLLK : T_ZQINIT;
    localparam int T_MAX1  = (T_XPR > T_MOD) ? T_XPR : T_MOD;
    localparam int T_MAX2  = (T_MAX1 > T_MRD) ? T_MAX1 : T_MRD;
    localparam int T_MAX   = (T_MAX2 > T_FINAL) ? T_MAX2 : T_FINAL;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    seq_state_t       state, state_nx;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: begin
                state_nx = S_XPR;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_XPR - 1);
            end
            S_XPR:    if (tmr_zero) state_nx = S_LD_MR2;
            S_LD_MR2: begin
                state_nx = S_GAP2;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MRD - 2);
            end
            S_GAP2:   if (tmr_zero) state_nx = S_LD_MR3;
            S_LD_MR3: begin
                state_nx = S_GAP3;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MRD - 2);
            end
            S_GAP3:   if (tmr_zero) state_nx = S_LD_MR1;
            S_LD_MR1: begin
                state_nx = S_GAP1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MRD - 2);
            end
            S_GAP1:   if (tmr_zero) state_nx = S_LD_MR0;
            S_LD_MR0: begin
                state_nx = S_GAPM;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_MOD - 2);
            end
            S_GAPM:   if (tmr_zero) state_nx = S_ZQCL;
            S_ZQCL: begin
                state_nx = S_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_FINAL - 2);
            end
            S_SETTLE: if (tmr_zero) state_nx = S_DONE;
            S_DONE:   state_nx = S_DONE;
            default:  state_nx = S_IDLE;
        endcase
    end

    ddr3_init_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
        .state     (state),
        .mr0_val   (mr0_val),
        .mr1_val   (mr1_val),
        .mr2_val   (mr2_val),
        .mr3_val   (mr3_val),
        .cke       (cke),
        .odt       (odt),
        .cs_n      (cs_n),
        .cmd       (cmd),
        .ba        (ba),
        .addr      (addr),
        .init_done (init_done)
    );

    // R2: clock enable never drops between resets
    a_r2_cke_held: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R10: device is selected whenever clock enable is high
    a_r10_cs_low: assert property (@(posedge clk) disable iff (rst)
        cke |-> !cs_n);

    // R4: a real command only follows an expired interval
    a_r4_cmd_after_timer: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && cmd != CMD_NOP) |-> $past(tmr_zero));

    // R6: extended register 1 write keeps the DLL enabled
    a_r6_dll_enable: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS && ba == BA_MR1) |-> !addr[0]);

    // R7: main register write requests a DLL reset
    a_r7_dll_reset: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MRS && ba == BA_MR0) |-> addr[8]);

    // R9: done is sticky and rises only after the final interval
    a_r9_done_held: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r9_done_after_timer: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(tmr_zero));

endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 16;
    localparam int T_XS     = 8;
    localparam int T_MRD    = 4;
    localparam int T_MOD    = 12;
    localparam int T_DLLK   = 512;
    localparam int T_ZQINIT = 512;

    localparam int XPR_E   = (T_XS > 5) ? T_XS : 5;
    localparam int FINAL_E = (T_DLLK > T_ZQINIT) ? T_DLLK : T_ZQINIT;
    localparam int OFS_MR0 = XPR_E + 3 * T_MRD;
    localparam int OFS_ZQ  = OFS_MR0 + T_MOD;
    localparam int DONE_T  = OFS_ZQ + FINAL_E;

    localparam int NV = 5;
    localparam int       V_OFS [NV] = '{XPR_E, XPR_E + T_MRD, XPR_E + 2*T_MRD, OFS_MR0, OFS_ZQ};
    localparam bit [2:0] V_CMD [NV] = '{3'b000, 3'b000, 3'b000, 3'b000, 3'b110};
    localparam bit [2:0] V_BA  [NV] = '{3'b010, 3'b011, 3'b001, 3'b000, 3'b000};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mr0_val = '0, mr1_val = '0, mr2_val = '0, mr3_val = '0;
    logic              cke, odt, cs_n, init_done;
    logic [2:0]        cmd, ba;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr3_init_seq #(
        .ADDR_W(ADDR_W), .T_XS(T_XS), .T_MRD(T_MRD), .T_MOD(T_MOD),
        .T_DLLK(T_DLLK), .T_ZQINIT(T_ZQINIT)
    ) u_ddr3_init_seq (
        .clk(clk), .rst(rst),
        .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val), .mr3_val(mr3_val),
        .cke(cke), .odt(odt), .cs_n(cs_n), .cmd(cmd), .ba(ba), .addr(addr),
        .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input int i);
        case (i)
            0: return mr2_val;
            1: return mr3_val;
            2: return mr1_val & ~ADDR_W'(1);
            3: return mr0_val | (ADDR_W'(1) << 8);
            default: return ADDR_W'(1) << 10;
        endcase
    endfunction

    task automatic check_reset_state(input string what);
        check(cke == 1'b0 && cs_n == 1'b1 && cmd == 3'b111 && init_done == 1'b0,
              "R1", what, {cke, cs_n, cmd, init_done}, 6'b011110);
    endtask

    // Hold reset, then release and walk the full sequence against the vector table
    task automatic run_sequence(input logic [ADDR_W-1:0] v0, v1, v2, v3, input int stop_at);
        int vi = 0;
        int nop_bad = 0;
        int cke_bad = 0;
        int odt_bad = 0;
        @(negedge clk);
        rst = 1'b1;
        mr0_val = v0; mr1_val = v1; mr2_val = v2; mr3_val = v3;
        repeat (2) @(negedge clk);
        check_reset_state("reset state");
        rst = 1'b0;
        for (int t = 0; t <= stop_at; t++) begin
            @(negedge clk);
            if (t == 0) check(cke == 1'b1, "R2", "cke one cycle after release", cke, 1);
            if (cke !== 1'b1) cke_bad++;
            if (odt !== 1'b0) odt_bad++;
            if (vi < NV && t == V_OFS[vi]) begin
                check(cs_n == 1'b0 && cmd == V_CMD[vi] && ba == V_BA[vi] && addr == exp_addr(vi),
                      (vi == 4) ? "R8" : ((vi == 2) ? "R6" : ((vi == 0) ? "R4" : "R5_R7")),
                      "command vector {cs_n,cmd,ba,addr}",
                      {cs_n, cmd, ba, addr}, {1'b0, V_CMD[vi], V_BA[vi], exp_addr(vi)});
                vi++;
            end else if (cs_n !== 1'b0 || cmd !== 3'b111) begin
                nop_bad++;
            end
            if (t == DONE_T - 1) check(init_done == 1'b0, "R9", "done one cycle early", init_done, 0);
            if (t == DONE_T)     check(init_done == 1'b1, "R9", "done on time", init_done, 1);
        end
        check(nop_bad == 0, "R10", "non-command cycles not NOP", nop_bad, 0);
        check(cke_bad == 0, "R2", "cycles with cke low", cke_bad, 0);
        check(odt_bad == 0, "R3", "cycles with odt high", odt_bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // Run 1: DLL bits already as required
        run_sequence(16'h1B40, 16'h0044, 16'h0018, 16'h0000, DONE_T + 8);
        check(init_done == 1'b1, "R9", "done held", init_done, 1);
        // Run 2: DLL bits set against the requirement; must be overridden (R6, R7)
        run_sequence(16'hA0B5, 16'h5A27, 16'hC3C3, 16'h0F0F, DONE_T + 4);
        // Reset after completion clears done (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("reset after done");
        // Reset in the middle of the tMOD gap (R1), then a clean restart
        run_sequence(16'h0520, 16'h0006, 16'h0010, 16'h0004, OFS_MR0 + 4);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("reset mid-sequence");
        run_sequence(16'h0520, 16'h0006, 16'h0010, 16'h0004, DONE_T + 2);
        report();
    end

endmodule